// File: doc/BRIEF.md
# DDR Mode Register Initialisation Sequencer

This block sits on the controller side of a DDR SDRAM channel. After reset it raises the clock-enable pin and drives NOP commands. It then programs the memory's mode registers in a fixed order, with one load of the extended register and two loads of the base register. The extended-register load turns the delay-locked loop (DLL) on and sets the drive strength. The first base-register load resets the DLL. The second base-register load returns the device to normal operating mode. A load is issued only while the `banks_idle` input reports that every bank is precharged and no burst is running. This input is the only link to the precharge and refresh logic. Between loads the block drives NOP commands for a programmable mode-register-set delay.

The block counts clock cycles with CKE high, starting from the DLL-reset load. When the lock count has run out, it raises `read_ok`, which allows the rest of the controller to issue READ commands. A debug input, `dll_off_req`, turns the DLL off through the extended register and drops `read_ok`. When the request is released, the whole enable, reset and normal sequence runs again, followed by a fresh lock count. All pins are plain control signals. Every command and address output comes from a register.

Top module: `ddr_mrs_sequencer`

## Requirements
- R1: While `rst_n` is low, `cke` is 0, `cs_n` is 1 and `read_ok` is 0. From the first cycle after reset, `cke` is 1 and stays 1.
- R2: Outside reset, the command pins {cs_n, ras_n, cas_n, we_n} carry only NOP (0,1,1,1) or mode-register load (0,0,0,0).
- R3: The first load after reset (and after every DLL re-enable) targets the extended register with ba = 2'b01. In it, addr[0] = 0 (DLL on), addr[1] = `DRIVE_HALF` (0 = full strength) and addr[12:2] = 0.
- R4: The second load targets the base register with ba = 2'b00. In it, addr[8] = 1 (DLL reset), addr[7] = 0, addr[12:9] = 0 and addr[6:0] = `MODE_BITS`.
- R5: The third load targets the base register with ba = 2'b00. In it, addr[12:7] = 0 and addr[6:0] = `MODE_BITS` (normal mode). No base load ever sets addr[7] or any bit of addr[12:9].
- R6: Two loads are separated by at least `MRD_CYC` NOP cycles. When `banks_idle` stays high, they are separated by exactly `MRD_CYC` NOP cycles.
- R7: No load is issued in a cycle after which `banks_idle` was sampled low. A pending load waits for as long as `banks_idle` stays low.
- R8: `read_ok` rises exactly `LOCK_CYC` cycles after the cycle in which the DLL-reset load appears on the pins, and never earlier.
- R9: When `dll_off_req` is sampled high while `read_ok` is high, `read_ok` is low in the next cycle. An extended load with ba = 2'b01, addr[0] = 1 and addr[1] = `DRIVE_HALF` follows. After that only NOPs are driven while the request stays high.
- R10: When `dll_off_req` falls after a disable, the sequence of R3, R4 and R5 runs again, and `read_ok` returns after the timing of R8.
- R11: A request sampled in the same cycle as the lock count expires takes priority, so `read_ok` does not rise and the disable load of R9 follows.
- R12: A request raised before the normal-mode load has no effect until that load has been issued. The three init loads still appear in order before the disable load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_idle | input | 1 | All banks idle and no burst in progress |
| dll_off_req | input | 1 | Debug request to hold the DLL disabled |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address; selects the base or extended mode register |
| addr | output | 13 | Address bus carrying the mode word |
| read_ok | output | 1 | READ commands permitted |

## Verification
Two events can fall in the same clock edge: the lock counter expiring, which would raise `read_ok`, and a debug disable request. The bench takes the cycle number of the DLL-reset load from the pins. It then raises `dll_off_req` so that the request is sampled on exactly the edge at which `read_ok` would otherwise rise. The result is judged by two observations: `read_ok` must show no rising edge at all, and the next load on the pins must be the DLL-off extended load. Running the full sequence again after the request is released confirms that the block recovers from the collision.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;

  typedef enum logic [1:0] {
    LK_EMR_ON,
    LK_EMR_OFF,
    LK_MR_DLLRST,
    LK_MR_NORM
  } load_kind_e;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_LOAD,
    ST_GAP,
    ST_LOCK,
    ST_READY,
    ST_HOLD
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ddr_cmd_t;

  localparam ddr_cmd_t CMD_DESEL = 4'b1111;
  localparam ddr_cmd_t CMD_NOP   = 4'b0111;
  localparam ddr_cmd_t CMD_LMR   = 4'b0000;

  localparam logic [BA_W-1:0] BA_BASE = 2'b00;
  localparam logic [BA_W-1:0] BA_EXT  = 2'b01;

endpackage

// File: rtl/ddr_mode_word.sv
module ddr_mode_word
  import ddr_seq_pkg::*;
#(
  parameter logic [6:0] MODE_BITS  = 7'h32,
  parameter bit         DRIVE_HALF = 1'b0
) (
  input  load_kind_e        kind,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  always_comb begin
    ba   = BA_BASE;
    addr = '0;
    unique case (kind)
      LK_EMR_ON: begin
        ba      = BA_EXT;
        addr[1] = DRIVE_HALF;
        addr[0] = 1'b0;
      end
      LK_EMR_OFF: begin
        ba      = BA_EXT;
        addr[1] = DRIVE_HALF;
        addr[0] = 1'b1;
      end
      LK_MR_DLLRST: begin
        addr[6:0] = MODE_BITS;
        addr[8]   = 1'b1;
      end
      LK_MR_NORM: begin
        addr[6:0] = MODE_BITS;
      end
      default: begin
        ba   = BA_BASE;
        addr = '0;
      end
    endcase
  end

endmodule

// File: rtl/ddr_tick_counter.sv
module ddr_tick_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '0;
    else if (load)
      count <= load_val;
    else if (count != '0)
      count <= count - W'(1);
  end

endmodule

// File: rtl/ddr_pin_driver.sv
module ddr_pin_driver
  import ddr_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [BA_W-1:0]   ba_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  ddr_cmd_t cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= CMD_DESEL;
      cke   <= 1'b0;
      ba    <= '0;
      addr  <= '0;
    end else begin
      cke <= 1'b1;
      if (issue) begin
        cmd_q <= CMD_LMR;
        ba    <= ba_in;
        addr  <= addr_in;
      end else begin
        cmd_q <= CMD_NOP;
        ba    <= '0;
        addr  <= '0;
      end
    end
  end

  assign cs_n  = cmd_q.cs_n;
  assign ras_n = cmd_q.ras_n;
  assign cas_n = cmd_q.cas_n;
  assign we_n  = cmd_q.we_n;

endmodule

// File: rtl/ddr_mrs_sequencer.sv
module ddr_mrs_sequencer
  import ddr_seq_pkg::*;
#(
  parameter int         MRD_CYC    = 2,
  parameter int         LOCK_CYC   = 200,
  parameter logic [6:0] MODE_BITS  = 7'h32,
  parameter bit         DRIVE_HALF = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        banks_idle,
  input  logic        dll_off_req,
  output logic        cke,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [1:0]  ba,
  output logic [12:0] addr,
  output logic        read_ok
);

  localparam int MRD_W  = $clog2(MRD_CYC + 1);
  localparam int LOCK_W = $clog2(LOCK_CYC + 1);

  seq_state_e state_q, state_d;
  load_kind_e kind_q, kind_d;
  logic       ok_d;
  logic       issue, gap_load, lock_load;

  logic [MRD_W-1:0]  gap_cnt;
  logic [LOCK_W-1:0] lock_cnt;
  logic [BA_W-1:0]   word_ba;
  logic [ADDR_W-1:0] word_addr;

  ddr_mode_word #(
    .MODE_BITS (MODE_BITS),
    .DRIVE_HALF(DRIVE_HALF)
  ) u_word (
    .kind(kind_q),
    .ba  (word_ba),
    .addr(word_addr)
  );

  ddr_tick_counter #(.W(MRD_W)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (gap_load),
    .load_val(MRD_W'(MRD_CYC)),
    .count   (gap_cnt)
  );

  ddr_tick_counter #(.W(LOCK_W)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (lock_load),
    .load_val(LOCK_W'(LOCK_CYC)),
    .count   (lock_cnt)
  );

  ddr_pin_driver u_pins (
    .clk    (clk),
    .rst_n  (rst_n),
    .issue  (issue),
    .ba_in  (word_ba),
    .addr_in(word_addr),
    .cke    (cke),
    .cs_n   (cs_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .ba     (ba),
    .addr   (addr)
  );

  always_comb begin
    state_d   = state_q;
    kind_d    = kind_q;
    ok_d      = read_ok;
    issue     = 1'b0;
    gap_load  = 1'b0;
    lock_load = 1'b0;
    unique case (state_q)
      ST_PWRUP: begin
        kind_d  = LK_EMR_ON;
        state_d = ST_LOAD;
      end
      ST_LOAD: begin
        if (banks_idle) begin
          issue     = 1'b1;
          gap_load  = 1'b1;
          lock_load = (kind_q == LK_MR_DLLRST);
          state_d   = ST_GAP;
        end
      end
      ST_GAP: begin
        if (gap_cnt == MRD_W'(1)) begin
          unique case (kind_q)
            LK_EMR_ON: begin
              kind_d  = LK_MR_DLLRST;
              state_d = ST_LOAD;
            end
            LK_MR_DLLRST: begin
              kind_d  = LK_MR_NORM;
              state_d = ST_LOAD;
            end
            LK_MR_NORM:  state_d = ST_LOCK;
            LK_EMR_OFF:  state_d = ST_HOLD;
            default:     state_d = ST_PWRUP;
          endcase
        end
      end
      ST_LOCK: begin
        if (dll_off_req) begin
          kind_d  = LK_EMR_OFF;
          state_d = ST_LOAD;
        end else if (lock_cnt <= LOCK_W'(1)) begin
          ok_d    = 1'b1;
          state_d = ST_READY;
        end
      end
      ST_READY: begin
        if (dll_off_req) begin
          ok_d    = 1'b0;
          kind_d  = LK_EMR_OFF;
          state_d = ST_LOAD;
        end
      end
      ST_HOLD: begin
        if (!dll_off_req) begin
          kind_d  = LK_EMR_ON;
          state_d = ST_LOAD;
        end
      end
      default: state_d = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_PWRUP;
      kind_q  <= LK_EMR_ON;
      read_ok <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      read_ok <= ok_d;
    end
  end

endmodule

// File: rtl/ddr_mrs_sequencer_chk.sv
module ddr_mrs_sequencer_chk #(
  parameter int MRD_CYC  = 2,
  parameter int LOCK_CYC = 200
) (
  input logic        clk,
  input logic        rst_n,
  input logic        banks_idle,
  input logic        dll_off_req,
  input logic        cke,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [1:0]  ba,
  input logic [12:0] addr,
  input logic        read_ok
);

  localparam int SW = $clog2(MRD_CYC + 1);
  localparam int LW = $clog2(LOCK_CYC + 1);

  logic          lmr;
  logic [SW-1:0] since_lmr;
  logic [LW-1:0] since_rst;
  logic          armed;

  assign lmr = !cs_n && !ras_n && !cas_n && !we_n;

  always_ff @(posedge clk) begin
    if (!rst_n)
      since_lmr <= SW'(MRD_CYC);
    else if (lmr)
      since_lmr <= '0;
    else if (since_lmr < SW'(MRD_CYC))
      since_lmr <= since_lmr + SW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      since_rst <= '0;
    end else if (lmr && ba == 2'b00 && addr[8]) begin
      armed     <= 1'b1;
      since_rst <= LW'(1);
    end else if (lmr && ba == 2'b01 && !addr[0]) begin
      armed     <= 1'b0;
      since_rst <= '0;
    end else if (armed && since_rst < LW'(LOCK_CYC)) begin
      since_rst <= since_rst + LW'(1);
    end
  end

  assert_cke_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cke);

  assert_legal_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> ({ras_n, cas_n, we_n} == 3'b111 || {ras_n, cas_n, we_n} == 3'b000));

  assert_emr_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lmr && ba == 2'b01) |-> (addr[12:2] == '0));

  assert_no_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lmr && ba == 2'b00) |-> (addr[12:9] == '0 && !addr[7]));

  assert_load_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lmr |-> since_lmr >= SW'(MRD_CYC));

  assert_load_needs_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lmr |-> $past(banks_idle));

  assert_lock_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(read_ok) |-> (armed && since_rst >= LW'(LOCK_CYC)));

  assert_debug_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (read_ok && dll_off_req) |=> !read_ok);

endmodule

bind ddr_mrs_sequencer ddr_mrs_sequencer_chk #(
  .MRD_CYC (MRD_CYC),
  .LOCK_CYC(LOCK_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .banks_idle (banks_idle),
  .dll_off_req(dll_off_req),
  .cke        (cke),
  .cs_n       (cs_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .ba         (ba),
  .addr       (addr),
  .read_ok    (read_ok)
);

// File: tb/tb_ddr_mrs_sequencer.sv
`timescale 1ns/1ps
module tb_ddr_mrs_sequencer;

  localparam int         MRD  = 3;
  localparam int         LOCK = 200;
  localparam logic [6:0] MODE = 7'h32;
  localparam bit         DRV  = 1'b1;

  localparam logic [12:0] W_EMR_ON  = {11'd0, DRV, 1'b0};
  localparam logic [12:0] W_EMR_OFF = {11'd0, DRV, 1'b1};
  localparam logic [12:0] W_DLLRST  = 13'h100 | {6'd0, MODE};
  localparam logic [12:0] W_NORM    = {6'd0, MODE};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic banks_idle = 1'b1;
  logic dll_off_req = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, read_ok;
  logic [1:0]  ba;
  logic [12:0] addr;

  int vectors = 0;
  int miscompares = 0;

  ddr_mrs_sequencer #(
    .MRD_CYC(MRD), .LOCK_CYC(LOCK), .MODE_BITS(MODE), .DRIVE_HALF(DRV)
  ) dut (
    .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .dll_off_req(dll_off_req),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .read_ok(read_ok)
  );

  always #4 clk = ~clk;

  // pin monitor, sampled 1 ns after each rising edge
  int          cyc = 0;
  int          n_loads = 0;
  logic [1:0]  log_ba   [0:15];
  logic [12:0] log_addr [0:15];
  int          log_cyc  [0:15];
  int          bad_cmd = 0;
  int          bad_cke = 0;
  int          n_rises = 0;
  int          rise_cyc = 0;
  logic        prev_ok = 1'b0;

  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    if (rst_n) begin
      if (!cke) bad_cke = bad_cke + 1;
      if ({cs_n, ras_n, cas_n, we_n} == 4'b0000) begin
        if (n_loads < 16) begin
          log_ba[n_loads]   = ba;
          log_addr[n_loads] = addr;
          log_cyc[n_loads]  = cyc;
        end
        n_loads = n_loads + 1;
      end else if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
        bad_cmd = bad_cmd + 1;
      end
      if (read_ok && !prev_ok) begin
        n_rises  = n_rises + 1;
        rise_cyc = cyc;
      end
    end
    prev_ok = read_ok;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors = vectors + 1;
    if (act !== exp) begin
      miscompares = miscompares + 1;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic idle);
    @(negedge clk);
    rst_n = 1'b0;
    banks_idle = idle;
    dll_off_req = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 cke in reset", {31'd0, cke}, 0);
    check("R1 cs_n in reset", {31'd0, cs_n}, 1);
    check("R1 read_ok in reset", {31'd0, read_ok}, 0);
    n_loads = 0; bad_cmd = 0; bad_cke = 0; n_rises = 0;
    rst_n = 1'b1;
  endtask

  task automatic wait_loads(input int k);
    for (int i = 0; i < 2000 && n_loads < k; i++) @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 2000 && !read_ok; i++) @(negedge clk);
  endtask

  task automatic check_words(input int i);
    check("R3 emr ba", {30'd0, log_ba[i]}, 1);
    check("R3 emr dll on", {19'd0, log_addr[i]}, W_EMR_ON);
    check("R4 dll reset ba", {30'd0, log_ba[i+1]}, 0);
    check("R4 dll reset word", {19'd0, log_addr[i+1]}, W_DLLRST);
    check("R5 normal ba", {30'd0, log_ba[i+2]}, 0);
    check("R5 normal word", {19'd0, log_addr[i+2]}, W_NORM);
  endtask

  task automatic check_timing(input int i);
    check("R6 gap emr-reset", log_cyc[i+1] - log_cyc[i], MRD + 1);
    check("R6 gap reset-normal", log_cyc[i+2] - log_cyc[i+1], MRD + 1);
    check("R8 lock span", rise_cyc - log_cyc[i+1], LOCK);
  endtask

  task automatic test_power_up();
    do_reset(1'b1);
    wait_ready();
    check("R8 read_ok up", {31'd0, read_ok}, 1);
    check("R3 load count", n_loads, 3);
    check_words(0);
    check_timing(0);
    check("R2 legal commands", bad_cmd, 0);
    check("R1 cke held", bad_cke, 0);
  endtask

  task automatic test_debug_disable();
    int k;
    k = n_loads;
    dll_off_req = 1'b1;
    @(negedge clk);
    check("R9 read_ok drop", {31'd0, read_ok}, 0);
    wait_loads(k + 1);
    check("R9 disable ba", {30'd0, log_ba[k]}, 1);
    check("R9 disable word", {19'd0, log_addr[k]}, W_EMR_OFF);
    repeat (40) @(negedge clk);
    check("R9 quiet while held", n_loads, k + 1);
    check("R9 read_ok stays low", {31'd0, read_ok}, 0);
    dll_off_req = 1'b0;
    wait_ready();
    check("R10 reload count", n_loads, k + 4);
    check_words(k + 1);
    check_timing(k + 1);
    check("R2 legal commands", bad_cmd, 0);
  endtask

  task automatic test_banks_busy();
    do_reset(1'b0);
    repeat (40) @(negedge clk);
    check("R7 no load while busy", n_loads, 0);
    banks_idle = 1'b1;
    wait_loads(1);
    banks_idle = 1'b0;
    repeat (30) @(negedge clk);
    check("R7 held mid-sequence", n_loads, 1);
    banks_idle = 1'b1;
    wait_ready();
    check("R7 resumes", n_loads, 3);
    check_words(0);
    check("R7 gap stretched", {31'd0, (log_cyc[1] - log_cyc[0]) >= 30}, 1);
    check("R8 lock after stretch", rise_cyc - log_cyc[1], LOCK);
  endtask

  task automatic test_collision();
    int t;
    do_reset(1'b1);
    wait_loads(2);
    t = log_cyc[1];
    while (cyc != t + LOCK - 1) @(negedge clk);
    dll_off_req = 1'b1;
    wait_loads(4);
    check("R11 no read_ok rise", n_rises, 0);
    check("R11 disable follows", {19'd0, log_addr[3]}, W_EMR_OFF);
    dll_off_req = 1'b0;
    wait_ready();
    check("R11 recovers", n_loads, 7);
    check_words(4);
  endtask

  task automatic test_early_request();
    do_reset(1'b1);
    @(negedge clk);
    dll_off_req = 1'b1;
    wait_loads(4);
    check_words(0);
    check("R12 disable after init", {19'd0, log_addr[3]}, W_EMR_OFF);
    check("R12 read_ok never up", n_rises, 0);
    dll_off_req = 1'b0;
    wait_ready();
    check("R12 ready after release", {31'd0, read_ok}, 1);
  endtask

  initial begin
    #1200000;
    miscompares = miscompares + 1;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    test_power_up();
    test_debug_disable();
    test_banks_busy();
    test_collision();
    test_early_request();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule